// File: doc/BRIEF.md
# Three-Stage Multicycle Calculator Core

This block is an 8-bit calculator that runs one instruction at a time. Each instruction takes three clocked steps. In decode, the core reads the operands. In execute, it computes the result. In writeback, it commits that result to one of four internal registers and shows it on the result port.

Explicit stage registers sit between the steps. An instruction's progress can therefore be followed cycle by cycle on a stage output.

Instructions enter through a valid/ready handshake. A new word is taken only while the core is idle. The supported operations are:

- loading a small signed constant into a register;
- adding two registers;
- negating one register.

Top module: `calc_core`

## Requirements
- R1: After reset, `instr_ready_o` is 1, `stage_o` is 0 and `result_valid_o` is 0. All four registers read as zero.
- R2: An instruction is accepted at a clock edge where `instr_valid_i` and `instr_ready_o` are both 1. After that edge, `stage_o` moves through 1 (decode), 2 (execute) and 3 (writeback), one cycle each, and then returns to 0 (idle). `instr_ready_o` is 1 only while `stage_o` is 0.
- R3: `result_valid_o` is a one-cycle pulse. It rises only while `stage_o` is 3. While it is high, `result_rd_o` carries the destination register index and `result_o` carries the value written.
- R4: Instruction bits [7:6] are the opcode and bits [5:4] select the destination register. Opcode 00 is load. Its bits [3:0] are a 4-bit two's-complement immediate, sign-extended to 8 bits (for example, 0xD loads 0xFD).
- R5: Opcode 01 is add. It writes the sum of the registers selected by bits [3:2] and bits [1:0], wrapped modulo 256.
- R6: Opcode 10 is negate. It writes the two's-complement negation of the register selected by bits [3:2]. Negating 0x00 gives 0x00, and negating 0x80 gives 0x80.
- R7: A register is written only at the end of writeback, so the next instruction sees the new value. Opcode 11 is a no-op: it still steps through the three stages, but produces no result pulse and changes no register.
- R8: An instruction word presented while `instr_ready_o` is 0 is ignored. It does not restart the stage sequence and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 8 | Instruction word |
| instr_valid_i | input | 1 | Instruction word is present |
| instr_ready_o | output | 1 | Core is idle and will take a word |
| stage_o | output | 2 | Current stage: 0 idle, 1 decode, 2 execute, 3 writeback |
| result_valid_o | output | 1 | Writeback strobe |
| result_rd_o | output | 2 | Destination register of the written value |
| result_o | output | 8 | Value written in writeback |

## Verification
The hardest case to reach from the ports is a word arriving while the core is busy. To create it, the bench raises `instr_valid_i` with a different instruction during decode and holds it through execute. It drops the request only in the middle of writeback, so the core sees the request at two edges where `instr_ready_o` is low. The bench then checks three things:

- the sequence stays idle afterwards;
- only the original instruction's result appeared;
- the register the ignored word targeted is unchanged, read back through an add.

The negate corner at 0x80 needs a register holding 0x80. The bench builds that value with a negative load and a chain of self-adds.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int unsigned INSTR_W = 8;
  localparam int unsigned REG_AW  = 2;
  localparam int unsigned NREG    = 1 << REG_AW;
  localparam int unsigned IMM_W   = 4;

  typedef enum logic [1:0] {
    OP_LD  = 2'b00,
    OP_ADD = 2'b01,
    OP_NEG = 2'b10,
    OP_NOP = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEC  = 2'd1,
    ST_EXE  = 2'd2,
    ST_WB   = 2'd3
  } stage_e;
endpackage

// File: rtl/calc_seq.sv
module calc_seq
  import calc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   accept_i,
  output stage_e stage_o,
  output logic   ready_o
);
  stage_e stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    unique case (stage_q)
      ST_IDLE: if (accept_i) stage_d = ST_DEC;
      ST_DEC:  stage_d = ST_EXE;
      ST_EXE:  stage_d = ST_WB;
      ST_WB:   stage_d = ST_IDLE;
      default: stage_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= ST_IDLE;
    else         stage_q <= stage_d;
  end

  assign stage_o = stage_q;
  assign ready_o = (stage_q == ST_IDLE);

  // R2
  dec_to_exe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == ST_DEC) |=> (stage_q == ST_EXE));
  // R2
  wb_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == ST_WB) |=> (stage_q == ST_IDLE));
endmodule

// File: rtl/calc_regfile.sv
module calc_regfile
  import calc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [REG_AW-1:0] raddr_a_i,
  input  logic [REG_AW-1:0] raddr_b_i,
  output logic [DW-1:0]     rdata_a_o,
  output logic [DW-1:0]     rdata_b_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (we_i && (waddr_i == REG_AW'(g)))      regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
endmodule

// File: rtl/calc_exec.sv
module calc_exec
  import calc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  opcode_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  localparam int unsigned EXT_W = DW - IMM_W;

  always_comb begin
    unique case (op_i)
      OP_LD:   res_o = {{EXT_W{a_i[IMM_W-1]}}, a_i[IMM_W-1:0]};
      OP_ADD:  res_o = a_i + b_i;
      OP_NEG:  res_o = ~a_i + DW'(1);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/calc_core.sv
module calc_core
  import calc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic              instr_valid_i,
  output logic              instr_ready_o,
  output logic [1:0]        stage_o,
  output logic              result_valid_o,
  output logic [REG_AW-1:0] result_rd_o,
  output logic [DW-1:0]     result_o
);
  typedef struct packed {
    opcode_e           op;
    logic [REG_AW-1:0] rd;
    logic [DW-1:0]     a;
    logic [DW-1:0]     b;
  } id_ex_t;

  typedef struct packed {
    opcode_e           op;
    logic [REG_AW-1:0] rd;
    logic [DW-1:0]     val;
  } ex_wb_t;

  stage_e              stage;
  logic                accept;
  logic [INSTR_W-1:0]  instr_q;
  id_ex_t              id_ex_q, id_ex_d;
  ex_wb_t              ex_wb_q;
  logic [DW-1:0]       rd_a, rd_b, exe_res;
  logic                wb_we;

  assign accept = instr_valid_i && instr_ready_o;

  calc_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .stage_o  (stage),
    .ready_o  (instr_ready_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     instr_q <= '0;
    else if (accept) instr_q <= instr_i;
  end

  // decode: source fields at [3:2] and [1:0], immediate in [3:0]
  calc_regfile #(.DW(DW)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wb_we),
    .waddr_i   (ex_wb_q.rd),
    .wdata_i   (ex_wb_q.val),
    .raddr_a_i (instr_q[3:2]),
    .raddr_b_i (instr_q[1:0]),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b)
  );

  always_comb begin
    id_ex_d.op = opcode_e'(instr_q[7:6]);
    id_ex_d.rd = instr_q[5:4];
    id_ex_d.a  = (id_ex_d.op == OP_LD) ? DW'(instr_q[IMM_W-1:0]) : rd_a;
    id_ex_d.b  = rd_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               id_ex_q <= '0;
    else if (stage == ST_DEC)  id_ex_q <= id_ex_d;
  end

  calc_exec #(.DW(DW)) u_exec (
    .op_i  (id_ex_q.op),
    .a_i   (id_ex_q.a),
    .b_i   (id_ex_q.b),
    .res_o (exe_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ex_wb_q <= '0;
    else if (stage == ST_EXE) ex_wb_q <= '{op: id_ex_q.op, rd: id_ex_q.rd, val: exe_res};
  end

  assign wb_we          = (stage == ST_WB) && (ex_wb_q.op != OP_NOP);
  assign result_valid_o = wb_we;
  assign result_rd_o    = ex_wb_q.rd;
  assign result_o       = ex_wb_q.val;
  assign stage_o        = stage;

  // R3
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);
  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_ready_o |=> (stage != ST_DEC));
  // R4
  ld_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage == ST_WB && ex_wb_q.op == OP_LD) |->
      (ex_wb_q.val[DW-1:IMM_W] == {(DW-IMM_W){ex_wb_q.val[IMM_W-1]}}));
  // R6
  neg_sum_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage == ST_WB && ex_wb_q.op == OP_NEG) |-> ((ex_wb_q.val + id_ex_q.a) == '0));
endmodule

// File: tb/calc_core_test.sv
module calc_core_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] instr_i = '0;
  logic       instr_valid_i = 1'b0;
  logic       instr_ready_o;
  logic [1:0] stage_o;
  logic       result_valid_o;
  logic [1:0] result_rd_o;
  logic [7:0] result_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [4];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  calc_core uut (
    .clk_i, .rst_ni, .instr_i, .instr_valid_i, .instr_ready_o,
    .stage_o, .result_valid_o, .result_rd_o, .result_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_val(input logic [7:0] ins);
    case (ins[7:6])
      2'b00:   return {{4{ins[3]}}, ins[3:0]};
      2'b01:   return model[ins[3:2]] + model[ins[1:0]];
      2'b10:   return 8'd0 - model[ins[3:2]];
      default: return 8'h00;
    endcase
  endfunction

  // runs one instruction; optionally presents a second word while busy (R8)
  task automatic run_op(input logic [7:0] ins, input string req,
                        input bit poke = 0, input logic [7:0] poke_ins = 8'h00);
    logic [7:0] ev;
    bit is_nop;
    ev = expect_val(ins);
    is_nop = (ins[7:6] == 2'b11);
    @(negedge clk_i);
    while (!instr_ready_o) @(negedge clk_i);
    instr_i = ins;
    instr_valid_i = 1'b1;
    @(negedge clk_i);
    instr_valid_i = 1'b0;
    if (poke) begin
      instr_i = poke_ins;
      instr_valid_i = 1'b1;
    end
    chk(stage_o == 2'd1, "R2 decode", stage_o, 1);
    chk(!instr_ready_o, "R2 busy", instr_ready_o, 0);
    chk(!result_valid_o, "R3 no early strobe", result_valid_o, 0);
    @(negedge clk_i);
    chk(stage_o == 2'd2, "R2 execute", stage_o, 2);
    chk(!result_valid_o, "R3 no early strobe", result_valid_o, 0);
    @(negedge clk_i);
    chk(stage_o == 2'd3, "R2 writeback", stage_o, 3);
    instr_valid_i = 1'b0;
    if (is_nop) begin
      chk(!result_valid_o, "R7 nop silent", result_valid_o, 0);
    end else begin
      chk(result_valid_o, "R3 strobe", result_valid_o, 1);
      chk(result_rd_o == ins[5:4], "R3 rd", result_rd_o, ins[5:4]);
      chk(result_o == ev, req, result_o, ev);
      model[ins[5:4]] = ev;
    end
    @(negedge clk_i);
    chk(stage_o == 2'd0, "R2 idle", stage_o, 0);
    chk(instr_ready_o, "R2 ready", instr_ready_o, 1);
    chk(!result_valid_o, "R3 one-cycle", result_valid_o, 0);
    if (poke) begin
      @(negedge clk_i);
      chk(stage_o == 2'd0, "R8 stays idle", stage_o, 0);
    end
  endtask

  task automatic t_reset();
    chk(instr_ready_o, "R1 ready", instr_ready_o, 1);
    chk(stage_o == 2'd0, "R1 stage", stage_o, 0);
    chk(!result_valid_o, "R1 strobe", result_valid_o, 0);
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    run_op(8'h71, "R1 regs zero (r3=r0+r1)");
    run_op(8'h4E, "R1 regs zero (r0=r3+r2)");
  endtask

  task automatic t_load();
    run_op(8'h05, "R4 load +5");
    run_op(8'h1D, "R4 load -3");
    run_op(8'h28, "R4 load -8");
    run_op(8'h37, "R4 load +7");
  endtask

  task automatic t_add();
    run_op(8'h71, "R5 add wrap 5+FD");
    run_op(8'h6A, "R5 add F8+F8");
    run_op(8'h43, "R5 add r0=r0+r3 (R7 sees prior write)");
  endtask

  task automatic t_neg();
    run_op(8'h90, "R6 negate r1=-r0");
    run_op(8'h6A, "R5 self-add");
    run_op(8'h6A, "R5 self-add");
    run_op(8'h6A, "R5 self-add to 80");
    run_op(8'hB8, "R6 negate 0x80");
    run_op(8'h00, "R4 load 0");
    run_op(8'h90, "R6 negate 0");
  endtask

  task automatic t_nop();
    run_op(8'hF0, "R7 nop");
    run_op(8'h4C, "R7 r3 unchanged after nop");
  endtask

  task automatic t_busy();
    run_op(8'h11, "R8 load r1=1", 1'b1, 8'h07);
    run_op(8'h70, "R8 r0 untouched by ignored word");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_load();
    t_add();
    t_neg();
    t_nop();
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule